// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block maps virtual addresses onto physical memory through a small on-chip table of segments. The top bits of a virtual address pick one table entry, and the remaining bits are the offset into that segment. Each entry holds a base address, a length limit, a present flag and a store-permission flag. The physical address is the entry's base plus the offset, wrapped to the physical address width.

An access is refused when any of these holds: the entry is not present, the offset reaches or passes the limit, or a store targets a segment without store permission. The result and the refusal flag are registered together and appear one cycle after the request. A refused access returns a zero address.

A separate configuration port loads table entries. Only writes marked privileged change the table. A write without privilege leaves the table as it was and raises a one-cycle violation pulse.

Top module: `seg_xlate`

## Requirements
- R1: After synchronous reset every table entry is not present, and `rsp_valid`, `rsp_err`, `rsp_pa` and `cfg_priv_err` are 0.
- R2: Bits [15:14] of `req_va` select the segment and bits [13:0] are the offset. For an accepted access, `rsp_pa` = base + offset.
- R3: An access whose offset is greater than or equal to the segment limit sets `rsp_err`. An offset of limit−1 is accepted.
- R4: An access to an entry whose present flag is 0 sets `rsp_err`.
- R5: When `req_wr`=1 and the entry's store-permission flag is 0, `rsp_err` is set. The same access with `req_wr`=0 is accepted.
- R6: `rsp_valid`, `rsp_pa` and `rsp_err` take effect one clock after a cycle with `req_valid`=1. `rsp_valid` is 0 after any cycle with `req_valid`=0.
- R7: A write with `cfg_we`=1 and `cfg_priv`=1 replaces entry `cfg_idx`. Requests from the next cycle onward see the new entry. A request in the same cycle as the write sees the old entry.
- R8: A write with `cfg_we`=1 and `cfg_priv`=0 leaves the table unchanged and sets `cfg_priv_err` for exactly one cycle on the next clock. `cfg_priv_err` is 0 otherwise.
- R9: When `rsp_err` is 1, `rsp_pa` is 0.
- R10: The sum base + offset is taken modulo 2^16.
- R11: Take this table: segment 0 with base 0x4000 and limit 0x0800, segment 1 with base 0x4800 and limit 0x1400. With it, virtual 0x0240 maps to 0x4240 and virtual 0x4050 maps to 0x4850.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Write is issued from privileged mode |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | New base address |
| cfg_limit | input | 15 | New limit (segment length) |
| cfg_present | input | 1 | New present flag |
| cfg_store_ok | input | 1 | New store-permission flag |
| cfg_priv_err | output | 1 | Unprivileged write was refused |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 16 | Virtual address |
| req_wr | input | 1 | 1 = store, 0 = load |
| rsp_valid | output | 1 | Response strobe |
| rsp_pa | output | 16 | Physical address (0 on error) |
| rsp_err | output | 1 | Access refused |

## Verification
The bench tests the limit edge at offsets of limit−1 and exactly limit. A comparison written with the wrong sense lets one extra word through or rejects the last legal one. It issues a store and a load to a read-only segment, so a permission check that ignores the direction fails one of the two. It sends a request in the same cycle as a table write, which exposes an entry that forwards the new value too early. It aims an unprivileged write at a live segment and then translates through that segment, so a table that takes the write shows a changed address. A base near the top of memory forces the sum to wrap. A design that extends the width of the sum or saturates it returns the wrong address.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    parameter int VA_W     = 16;
    parameter int SEG_BITS = 2;
    parameter int PA_W     = 16;

    localparam int OFF_W   = VA_W - SEG_BITS;
    localparam int LIM_W   = OFF_W + 1;
    localparam int NUM_SEG = 1 << SEG_BITS;

    typedef logic [SEG_BITS-1:0] seg_idx_t;
    typedef logic [OFF_W-1:0]    seg_off_t;
    typedef logic [PA_W-1:0]     phys_addr_t;
    typedef logic [LIM_W-1:0]    seg_lim_t;

    typedef struct packed {
        phys_addr_t base;
        seg_lim_t   limit;
        logic       present;
        logic       store_ok;
    } seg_entry_t;

    localparam int ENT_W = $bits(seg_entry_t);

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_BOUNDS  = 2'd2,
        FLT_PERM    = 2'd3
    } fault_e;

    typedef struct packed {
        phys_addr_t pa;
        fault_e     fault;
    } xlate_res_t;

    function automatic seg_idx_t va_seg(input logic [VA_W-1:0] va);
        return va[VA_W-1 -: SEG_BITS];
    endfunction

    function automatic seg_off_t va_off(input logic [VA_W-1:0] va);
        return va[OFF_W-1:0];
    endfunction

    function automatic phys_addr_t wrap_add(input phys_addr_t base, input seg_off_t off);
        phys_addr_t ext;
        ext = PA_W'(off);
        return base + ext;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       priv,
    input  seg_idx_t   wr_idx,
    input  seg_entry_t wr_entry,
    input  seg_idx_t   rd_idx,
    output seg_entry_t rd_entry,
    output logic       priv_err
);

    seg_entry_t               ent_q [NUM_SEG];
    logic [NUM_SEG*ENT_W-1:0] ent_flat;
    logic                     wr_accept;

    assign wr_accept = we && priv;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_accept && (wr_idx == seg_idx_t'(g))) begin
                ent_q[g] <= wr_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            priv_err <= 1'b0;
        end else begin
            priv_err <= we && !priv;
        end
    end

    assign rd_entry = ent_q[rd_idx];

    always_comb begin
        for (int i = 0; i < NUM_SEG; i++) begin
            ent_flat[i*ENT_W +: ENT_W] = ent_q[i];
        end
    end

    // R8: a refused write touches no entry
    p_ignore_r8: assert property (@(posedge clk) disable iff (rst)
        (we && !priv) |=> $stable(ent_flat));

    // R7: an accepted write lands in the addressed entry
    p_store_r7: assert property (@(posedge clk) disable iff (rst)
        (we && priv) |=> (ent_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlate_pkg::*;
(
    input  seg_entry_t entry,
    input  seg_off_t   off,
    input  logic       is_store,
    output xlate_res_t res
);

    logic over_limit;
    logic perm_bad;

    assign over_limit = seg_lim_t'(off) >= entry.limit;
    assign perm_bad   = is_store && !entry.store_ok;

    always_comb begin
        res.pa    = wrap_add(entry.base, off);
        res.fault = FLT_NONE;
        if (!entry.present) begin
            res.fault = FLT_ABSENT;
        end else if (over_limit) begin
            res.fault = FLT_BOUNDS;
        end else if (perm_bad) begin
            res.fault = FLT_PERM;
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic                cfg_priv,
    input  logic [SEG_BITS-1:0] cfg_idx,
    input  logic [PA_W-1:0]     cfg_base,
    input  logic [LIM_W-1:0]    cfg_limit,
    input  logic                cfg_present,
    input  logic                cfg_store_ok,
    output logic                cfg_priv_err,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_va,
    input  logic                req_wr,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_pa,
    output logic                rsp_err
);

    seg_entry_t wr_entry;
    seg_entry_t cur_entry;
    xlate_res_t res;
    seg_off_t   req_off;

    assign wr_entry = '{base: cfg_base, limit: cfg_limit,
                        present: cfg_present, store_ok: cfg_store_ok};
    assign req_off  = va_off(req_va);

    seg_table u_table (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .priv     (cfg_priv),
        .wr_idx   (cfg_idx),
        .wr_entry (wr_entry),
        .rd_idx   (va_seg(req_va)),
        .rd_entry (cur_entry),
        .priv_err (cfg_priv_err)
    );

    seg_check u_check (
        .entry    (cur_entry),
        .off      (req_off),
        .is_store (req_wr),
        .res      (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && (res.fault != FLT_NONE);
            rsp_pa    <= (req_valid && (res.fault == FLT_NONE)) ? res.pa : '0;
        end
    end

    // R6: one-cycle response latency
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R4: absent entry always refused
    p_absent_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur_entry.present) |=> rsp_err);

    // R5: store to a read-only segment refused
    p_perm_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_wr && !cur_entry.store_ok) |=> rsp_err);

    // R9: refused access carries a zero address
    p_zero_pa_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_pa == '0));

    // R8: violation pulse follows an unprivileged write
    p_priv_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_priv) |=> cfg_priv_err);

endmodule

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
    import seg_xlate_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                cfg_we, cfg_priv, cfg_present, cfg_store_ok;
    logic [SEG_BITS-1:0] cfg_idx;
    logic [PA_W-1:0]     cfg_base;
    logic [LIM_W-1:0]    cfg_limit;
    logic                cfg_priv_err;
    logic                req_valid, req_wr;
    logic [VA_W-1:0]     req_va;
    logic                rsp_valid, rsp_err;
    logic [PA_W-1:0]     rsp_pa;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [PA_W-1:0]  m_base [NUM_SEG];
    logic [LIM_W-1:0] m_lim  [NUM_SEG];
    logic             m_pres [NUM_SEG];
    logic             m_wok  [NUM_SEG];

    always #10 clk = ~clk;

    seg_xlate dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_err(input logic [VA_W-1:0] va, input logic wr);
        int s = int'(va[VA_W-1 -: SEG_BITS]);
        int o = int'(va[OFF_W-1:0]);
        if (!m_pres[s]) return 1;
        if (o >= int'(m_lim[s])) return 1;
        if (wr && !m_wok[s]) return 1;
        return 0;
    endfunction

    function automatic logic [PA_W-1:0] exp_pa(input logic [VA_W-1:0] va, input logic wr);
        int s = int'(va[VA_W-1 -: SEG_BITS]);
        if (exp_err(va, wr)) return '0;
        return PA_W'(int'(m_base[s]) + int'(va[OFF_W-1:0]));
    endfunction

    task automatic xlate(input logic [VA_W-1:0] va, input logic wr, input string tag);
        logic          e;
        logic [PA_W-1:0] p;
        e = exp_err(va, wr);
        p = exp_pa(va, wr);
        @(negedge clk);
        req_valid = 1; req_va = va; req_wr = wr;
        @(negedge clk);
        req_valid = 0;
        chk(rsp_valid == 1'b1, {tag, " R6 valid"}, int'(rsp_valid), 1);
        chk(rsp_err == e, {tag, " err"}, int'(rsp_err), int'(e));
        chk(rsp_pa == p, {tag, " pa"}, int'(rsp_pa), int'(p));
    endtask

    task automatic cfg(input int idx, input int base, input int lim,
                       input bit pres, input bit wok, input bit priv, input string tag);
        @(negedge clk);
        cfg_we = 1; cfg_priv = priv; cfg_idx = SEG_BITS'(idx);
        cfg_base = PA_W'(base); cfg_limit = LIM_W'(lim);
        cfg_present = pres; cfg_store_ok = wok;
        @(negedge clk);
        cfg_we = 0;
        chk(cfg_priv_err == !priv, {tag, " R8 priv_err"}, int'(cfg_priv_err), int'(!priv));
        if (priv) begin
            m_base[idx] = PA_W'(base); m_lim[idx] = LIM_W'(lim);
            m_pres[idx] = pres; m_wok[idx] = wok;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5E61_0001));
        for (int i = 0; i < NUM_SEG; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_pres[i] = 0; m_wok[i] = 0;
        end
        rst = 1; cfg_we = 0; cfg_priv = 0; cfg_idx = '0; cfg_base = '0;
        cfg_limit = '0; cfg_present = 0; cfg_store_ok = 0;
        req_valid = 0; req_va = '0; req_wr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(rsp_valid == 0 && rsp_err == 0 && rsp_pa == 0, "R1 outputs", int'(rsp_pa), 0);
        chk(cfg_priv_err == 0, "R1 priv_err", int'(cfg_priv_err), 0);
        for (int s = 0; s < NUM_SEG; s++) xlate(VA_W'(s << OFF_W), 0, "R1 R4 empty table");

        // example table
        cfg(0, 'h4000, 'h0800, 1, 0, 1, "setup0");
        cfg(1, 'h4800, 'h1400, 1, 1, 1, "setup1");
        cfg(2, 'hF000, 'h1000, 1, 1, 1, "setup2");
        cfg(3, 'h0000, 'h3000, 1, 1, 1, "setup3");

        // R11 / R2 worked example
        xlate('h0240, 0, "R11 R2 code fetch");
        chk(rsp_pa == 16'h4240, "R11 0x0240", int'(rsp_pa), 'h4240);
        xlate('h4050, 0, "R11 R2 data load");
        chk(rsp_pa == 16'h4850, "R11 0x4050", int'(rsp_pa), 'h4850);

        // R3 limit edges
        xlate('h07FF, 0, "R3 last word");
        chk(rsp_err == 0, "R3 limit-1 ok", int'(rsp_err), 0);
        xlate('h0800, 0, "R3 at limit");
        chk(rsp_err == 1, "R3 offset==limit", int'(rsp_err), 1);
        xlate('h3FFF, 0, "R3 far beyond");

        // R5 permission
        xlate('h0010, 1, "R5 store ro");
        chk(rsp_err == 1 && rsp_pa == 0, "R5 R9 store refused", int'(rsp_pa), 0);
        xlate('h0010, 0, "R5 load ro");
        chk(rsp_err == 0, "R5 load ok", int'(rsp_err), 0);
        xlate('h4010, 1, "R5 store rw");

        // R6 idle cycle
        @(negedge clk);
        chk(rsp_valid == 0, "R6 idle", int'(rsp_valid), 0);

        // R10 wrap
        cfg(2, 'hF800, 'h1000, 1, 1, 1, "wrap setup");
        xlate('h8900, 0, "R10 wrap");
        chk(rsp_pa == 16'h0100, "R10 wrapped pa", int'(rsp_pa), 'h0100);

        // R8 unprivileged write to live segment
        cfg(1, 'h1234, 'h0001, 0, 0, 0, "R8 refused write");
        xlate('h4050, 1, "R8 table unchanged");
        chk(rsp_pa == 16'h4850, "R8 seg1 intact", int'(rsp_pa), 'h4850);
        @(negedge clk);
        chk(cfg_priv_err == 0, "R8 single pulse", int'(cfg_priv_err), 0);

        // R4 mark absent
        cfg(3, 'h0000, 'h3000, 0, 1, 1, "absent setup");
        xlate('hC004, 0, "R4 absent seg3");
        chk(rsp_err == 1, "R4 err", int'(rsp_err), 1);

        // R7 same-cycle write sees old entry
        @(negedge clk);
        cfg_we = 1; cfg_priv = 1; cfg_idx = 0; cfg_base = 16'h2000;
        cfg_limit = 15'h0800; cfg_present = 1; cfg_store_ok = 0;
        req_valid = 1; req_va = 16'h0004; req_wr = 0;
        @(negedge clk);
        cfg_we = 0; req_valid = 0;
        chk(rsp_pa == 16'h4004, "R7 same-cycle old entry", int'(rsp_pa), 'h4004);
        m_base[0] = 16'h2000;
        xlate('h0004, 0, "R7 next cycle new entry");
        chk(rsp_pa == 16'h2004, "R7 new base", int'(rsp_pa), 'h2004);

        // constrained random
        for (int n = 0; n < 400; n++) begin
            if (($urandom % 8) == 0) begin
                cfg(int'($urandom % NUM_SEG), int'($urandom % 65536),
                    int'($urandom % (1 << LIM_W)), ($urandom % 4) != 0,
                    $urandom % 2, ($urandom % 4) != 0, "R7 R8 random cfg");
            end else begin
                xlate(VA_W'($urandom), $urandom % 2, "R2 R3 R4 R5 random");
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule